// File: doc/BRIEF.md
# Iterative Shift-Add Integer Multiplier

This block multiplies two operands of `W` bits (32 by default) and forms a product of `2W` bits in a pair of registers, `hi` (upper half) and `lo` (lower half). It uses one adder of `W+1` bits and one clock cycle for each multiplier bit. A one-cycle `start` pulse captures the multiplicand, the multiplier and the `signed_mode` select. The block then runs `W` iterations and pulses `done` once the product is in `hi`/`lo`. The result stays in those registers until the next accepted start, so the surrounding pipeline can read it at any later time.

The multiplier shares the register with the lower product half. At load, `lo` takes the multiplier and `hi` is cleared. Each iteration tests `lo[0]`. When that bit is 1, the multiplicand is added into `hi`, and in the same cycle the pair `{hi, lo}` moves right by one bit. The bit that enters the top of `hi` comes from the `W+1`-bit sum: in unsigned mode it is the carry, and in signed mode it is the sign of the sign-extended sum. In signed mode the final iteration subtracts the multiplicand instead of adding it, which gives the multiplier's top bit its negative weight.

The controller is a three-state machine:
- IDLE waits. Its transition IDLE→RUN happens on an accepted start.
- RUN iterates. The transition RUN→RUN happens while the iteration count is below `W-1`. The transition RUN→DONE happens on the final iteration.
- DONE presents `done` for one cycle. Its transition DONE→RUN happens when a start arrives in that cycle. Otherwise it takes the transition DONE→IDLE.

A start seen while in RUN is ignored.

Top module: `seq_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hi`, `lo`, `busy` and `done` are all 0.
- R2: With `signed_mode`=0 at start, the value `{hi, lo}` in the `done` cycle equals the unsigned product of the two operands, as a `2W`-bit number.
- R3: With `signed_mode`=1 at start, the value `{hi, lo}` in the `done` cycle equals the two's-complement product of the two operands, as a `2W`-bit number. For example, (-4) × (-3) gives +12.
- R4: `done` is high for exactly one cycle. It rises `W` rising edges after the edge that samples an accepted start.
- R5: `busy` is high for exactly the `W` cycles between an accepted start and its `done`, and never together with `done`. A start is accepted when `busy` is 0, including in the `done` cycle, which allows back-to-back operations.
- R6: Outside RUN, and without a new accepted start, `hi` and `lo` keep their values.
- R7: Operands and mode are taken only at the accepted start. A start pulse, new operand values or a new mode presented while `busy` is 1 have no effect on the result or on its timing.
- R8: Operands of 0, all ones and the most negative value (only the top bit set) give the correct product in both modes.
- R9: In the cycle after an accepted start, `hi` is 0 and `lo` equals the sampled multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only when busy is 0 |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| multiplicand | input | W | Multiplicand, sampled at the accepted start |
| multiplier | input | W | Multiplier, sampled at the accepted start |
| busy | output | 1 | High during the W iteration cycles |
| done | output | 1 | One-cycle pulse when the product is valid |
| hi | output | W | Upper half of the product register |
| lo | output | W | Lower half of the product register, which holds the multiplier at load |

## Verification
The `done` pulse and its product fall exactly `W` rising edges after the edge that samples the accepted start. The load state (`hi`=0, `lo`=multiplier) is due one edge after that edge. The driver stamps every issued operation with the cycle in which its `done` must appear and pushes the expected product into a queue. A monitor samples on falling edges, pops one entry for each `done`, and compares both the product and the cycle number. The checks for the load state, for ignored mid-run starts and operand changes, and for result hold over idle cycles are made at falling edges at those same fixed offsets.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;

    typedef struct packed {
        logic load;
        logic step;
        logic last;
    } mul_ctl_t;

endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
    import seq_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    output mul_ctl_t ctl,
    output logic     busy,
    output logic     done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    mul_state_e state_q, state_d;
    logic [CW-1:0] iter_q;
    logic accept;
    logic at_last;

    assign accept  = start && (state_q != ST_RUN);
    assign at_last = (iter_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RUN;
            ST_RUN:  if (at_last) state_d = ST_DONE;
            ST_DONE: state_d = accept ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_q <= '0;
        end else if (accept) begin
            iter_q <= '0;
        end else if (state_q == ST_RUN) begin
            iter_q <= iter_q + 1'b1;
        end
    end

    always_comb begin
        ctl.load = accept;
        ctl.step = 1'b0;
        ctl.last = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                ctl.step = 1'b1;
                ctl.last = at_last;
                busy     = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/seq_mul_addsub.sv
module seq_mul_addsub #(
    parameter int AW = 33
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          sub,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + AW'(sub);
    end

endmodule

// File: rtl/seq_mul_datapath.sv
module seq_mul_datapath
    import seq_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mul_ctl_t     ctl,
    input  logic         signed_mode,
    input  logic [W-1:0] multiplicand,
    input  logic [W-1:0] multiplier,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    localparam int AW = W + 1;

    logic [W-1:0]  hi_q, lo_q, mcand_q;
    logic          smode_q;
    logic [AW-1:0] ext_hi, ext_mc, addend, sum;
    logic          do_sub;

    always_comb begin
        ext_hi = {smode_q & hi_q[W-1], hi_q};
        ext_mc = {smode_q & mcand_q[W-1], mcand_q};
        addend = lo_q[0] ? ext_mc : '0;
        do_sub = ctl.last & smode_q & lo_q[0];
    end

    seq_mul_addsub #(.AW(AW)) u_add (
        .a   (ext_hi),
        .b   (addend),
        .sub (do_sub),
        .sum (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            mcand_q <= '0;
            smode_q <= 1'b0;
        end else if (ctl.load) begin
            hi_q    <= '0;
            lo_q    <= multiplier;
            mcand_q <= multiplicand;
            smode_q <= signed_mode;
        end else if (ctl.step) begin
            hi_q <= sum[AW-1:1];
            lo_q <= {sum[0], lo_q[W-1:1]};
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

endmodule

// File: rtl/seq_mul.sv
module seq_mul
    import seq_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] multiplicand,
    input  logic [W-1:0] multiplier,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    mul_ctl_t ctl;

    seq_mul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    seq_mul_datapath #(.W(W)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl          (ctl),
        .signed_mode  (signed_mode),
        .multiplicand (multiplicand),
        .multiplier   (multiplier),
        .hi           (hi),
        .lo           (lo)
    );

endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] multiplier,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);
    localparam int KW = $clog2(W + 2) + 1;
    localparam logic [KW-1:0] KMAX = {KW{1'b1}};

    logic [KW-1:0] since_q;
    logic          armed_q;
    logic          acc;

    assign acc = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            armed_q <= 1'b0;
        end else if (acc) begin
            since_q <= '0;
            armed_q <= 1'b1;
        end else begin
            if (since_q != KMAX) since_q <= since_q + 1'b1;
            if (done) armed_q <= 1'b0;
        end
    end

    // R1
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (!busy && !done && hi == '0 && lo == '0);
        end
    end

    // R4
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (armed_q && since_q == KW'(W)));

    // R5
    a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);

    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(hi) && $stable(lo)));

    // R9
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (hi == '0 && lo == $past(multiplier)));

endmodule

bind seq_mul seq_mul_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .multiplier (multiplier),
    .busy       (busy),
    .done       (done),
    .hi         (hi),
    .lo         (lo)
);

// File: tb/seq_mul_test.sv
`timescale 1ns/1ps
module seq_mul_test;
    localparam int W = 32;
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] multiplicand = '0;
    logic [W-1:0] multiplier = '0;
    logic         busy, done;
    logic [W-1:0] hi, lo;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    logic [2*W-1:0] exp_q[$];
    int             due_q[$];
    string          tag_q[$];

    seq_mul #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .multiplicand(multiplicand), .multiplier(multiplier),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [2*W-1:0] ref_prod(logic [W-1:0] a, logic [W-1:0] b, logic sm);
        logic [2*W-1:0] ea, eb;
        ea = sm ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        eb = sm ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return ea * eb;
    endfunction

    task automatic check(bit ok, string tag, logic [2*W-1:0] act, logic [2*W-1:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // called at a falling edge; leaves at the next falling edge with start low
    task automatic issue(logic [W-1:0] a, logic [W-1:0] b, logic sm, string tag);
        multiplicand = a;
        multiplier   = b;
        signed_mode  = sm;
        start        = 1'b1;
        exp_q.push_back(ref_prod(a, b, sm));
        due_q.push_back(cyc + 1 + W);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        check(hi == '0 && lo == b && busy, "R9 load", {hi, lo}, {{W{1'b0}}, b});
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run(logic [W-1:0] a, logic [W-1:0] b, logic sm, string tag);
        issue(a, b, sm, tag);
        wait_done();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected done", {hi, lo}, '0);
            end else begin
                logic [2*W-1:0] e;
                int d;
                string t;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                t = tag_q.pop_front();
                check({hi, lo} == e, t, {hi, lo}, e);
                check(cyc == d && !busy, "R4 R5 done timing", 2*W'(cyc), 2*W'(d));
            end
        end
    end

    initial begin
        #100000;
        check(1'b0, "watchdog", 2*W'(cyc), '0);
        summary();
    end

    initial begin
        logic [2*W-1:0] held;
        repeat (3) @(negedge clk);
        check(!busy && !done && hi == '0 && lo == '0, "R1 reset", {hi, lo}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && hi == '0 && lo == '0, "R1 after reset", {hi, lo}, '0);

        // signed example and assorted patterns
        run(32'hFFFF_FFFC, 32'hFFFF_FFFD, 1'b1, "R3 (-4)x(-3)");
        run(32'hFFFF_FFFC, 32'd5, 1'b1, "R3 neg x pos");
        run(32'd7, 32'hFFFF_FFF9, 1'b1, "R3 pos x neg");
        run(32'd12, 32'd13, 1'b0, "R2 small");
        run(32'hDEAD_BEEF, 32'h1234_5678, 1'b0, "R2 pattern");
        run(32'hDEAD_BEEF, 32'h1234_5678, 1'b1, "R3 pattern");
        run(32'h8765_4321, 32'hFEDC_BA98, 1'b0, "R2 high bits");

        // corner operands, both modes
        for (int m = 0; m < 2; m++) begin
            run('0, ONES, m[0], m ? "R8 R3 zero x ones" : "R8 R2 zero x ones");
            run(ONES, '0, m[0], m ? "R8 R3 ones x zero" : "R8 R2 ones x zero");
            run(ONES, ONES, m[0], m ? "R8 R3 ones x ones" : "R8 R2 ones x ones");
            run(MINV, MINV, m[0], m ? "R8 R3 min x min" : "R8 R2 min x min");
            run(MINV, ONES, m[0], m ? "R8 R3 min x ones" : "R8 R2 min x ones");
            run(32'd1, MINV, m[0], m ? "R8 R3 one x min" : "R8 R2 one x min");
        end

        // R6: result holds over idle cycles
        @(negedge clk);
        held = {hi, lo};
        repeat (5) @(negedge clk);
        check({hi, lo} == held && !busy, "R6 hold idle", {hi, lo}, held);

        // R7: start and input changes while busy are ignored
        issue(32'd1000, 32'd3000, 1'b0, "R7 R2 ignored mid-run start");
        repeat (4) @(negedge clk);
        multiplicand = 32'hAAAA_5555;
        multiplier   = 32'h0F0F_F0F0;
        signed_mode  = 1'b1;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        multiplicand = ONES;
        wait_done();

        // R5: back-to-back start in done cycle
        issue(32'hFFFF_FFF0, 32'd16, 1'b1, "R5 R3 back-to-back 1");
        wait_done();
        issue(32'd65535, 32'd65537, 1'b0, "R5 R2 back-to-back 2");
        wait_done();
        @(negedge clk);
        held = {hi, lo};
        repeat (3) @(negedge clk);
        check({hi, lo} == held, "R6 hold after back-to-back", {hi, lo}, held);
        check(exp_q.size() == 0, "R4 all results seen", 2*W'(exp_q.size()), '0);
        summary();
    end

endmodule